// File: doc/BRIEF.md
# Accumulator Byte ALU with Condition Flags

This block is the combinational arithmetic and logic unit of an accumulator-based 8-bit processor. Each cycle it takes the accumulator, a second operand, the current flag byte and a 4-bit operation code. From these it produces a result byte, a new flag byte and a write-enable for the accumulator. Operand fetch, instruction decode and 16-bit arithmetic are handled elsewhere. The surrounding datapath writes `result_o` into the accumulator when `acc_we_o` is high, and writes `flags_o` into the flag register every time.

Each class of operation updates its own set of flags. Arithmetic operations report signed overflow on the shared parity/overflow bit. Logic operations report even parity on that same bit. The complement and carry operations keep most of the incoming flags. Decimal adjust uses the half-carry, subtract and carry flags left by the previous add or subtract, so that the accumulator becomes a valid packed BCD value.

Top module: `alu8_core`

## Requirements
- R1: Flag byte layout, for both `flags_i` and `flags_o`: bit7 sign, bit6 zero, bit4 half-carry, bit2 parity/overflow, bit1 subtract, bit0 carry. Bits 5 and 3 of `flags_o` copy bits 5 and 3 of the computed value. That value is the difference for compare, and `result_o` for every other operation.
- R2: Operation codes: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 compare, 5 AND, 6 OR, 7 XOR, 8 negate, 9 complement, 10 complement carry, 11 set carry, 12 decimal adjust. Add (0) returns A+B and ignores the carry in. Add with carry (1) returns A+B+C. Both clear the subtract flag, set the carry flag to the carry out of bit 7, and set sign and zero from the result.
- R3: Subtract (2) returns A-B, subtract with carry (3) returns A-B-C, and negate (8) returns 0-A. All three set the subtract flag. The carry flag is set when a borrow out of bit 7 occurs.
- R4: For codes 0 to 4 and 8, the parity/overflow bit is set exactly when two's-complement signed overflow occurs.
- R5: For codes 0 to 4 and 8, the half-carry flag is the carry out of bit 3 for addition, or the borrow from bit 4 for subtraction.
- R6: Compare (4) sets the flags as subtract would for A-B. It returns A unchanged on `result_o` and drives `acc_we_o` low. Codes 0 to 3 and 5 to 12 drive `acc_we_o` high.
- R7: AND (5) sets half-carry, clears subtract and carry, and sets parity/overflow to 1 when the result has an even number of one bits.
- R8: OR (6) and XOR (7) clear half-carry, subtract and carry, and set parity/overflow to the even parity of the result.
- R9: Complement (9) returns the bitwise inverse of A and sets half-carry and subtract. It keeps the incoming sign, zero, parity/overflow and carry flags.
- R10: Set carry (11) forces carry to 1 and clears half-carry and subtract. Complement carry (10) inverts carry, clears subtract and moves the old carry into half-carry. Both return A and keep sign, zero and parity/overflow.
- R11: Decimal adjust (12) applies two corrections to A. The low correction is 0x06, used when the low nibble is above 9 or the incoming half-carry is set. The high correction is 0x60, used when A is above 0x99 or the incoming carry is set. The corrections are added when the incoming subtract flag is clear and subtracted when it is set. Carry out is the incoming carry OR (A > 0x99). Half-carry out is (low nibble > 9) when adding, or (incoming H AND low nibble < 6) when subtracting. The subtract flag is kept, parity/overflow is even parity, and sign and zero follow the result.
- R12: Codes 13 to 15 return A, pass `flags_i` through unchanged and drive `acc_we_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| flags_i | input | 8 | Current flag byte |
| op_i | input | 4 | Operation code |
| result_o | output | 8 | Result byte |
| flags_o | output | 8 | New flag byte |
| acc_we_o | output | 1 | Accumulator write-enable |

## Verification
The hardest case to reach is decimal adjust. Its output depends on flags that an earlier subtraction must have left behind, namely subtract set together with half-carry or carry. The bench builds these flag bytes by hand to match real preceding operations, such as 0x42-0x15 and 0x10-0x20, and then checks that the corrections are subtracted rather than added. Signed overflow on negate of 0x80, and a subtract with carry whose only borrow comes from the carry in, are driven directly with chosen operand pairs.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int unsigned DW   = 8;
    localparam int unsigned NIB  = DW / 2;
    localparam int unsigned OPW  = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_CMP  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_NEG  = 4'd8,
        OP_CPL  = 4'd9,
        OP_CCF  = 4'd10,
        OP_SCF  = 4'd11,
        OP_DAA  = 4'd12,
        OP_RSV0 = 4'd13,
        OP_RSV1 = 4'd14,
        OP_RSV2 = 4'd15
    } alu_op_e;

    // Packed from bit7 down to bit0.
    typedef struct packed {
        logic s;
        logic z;
        logic b5;
        logic h;
        logic b3;
        logic pv;
        logic n;
        logic c;
    } flag_t;

    function automatic logic even_par(input logic [DW-1:0] v);
        return ~(^v);
    endfunction

    function automatic logic is_arith(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
               (op == OP_SBC) || (op == OP_CMP) || (op == OP_NEG);
    endfunction

    function automatic logic is_subtract(input alu_op_e op);
        return (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) ||
               (op == OP_NEG);
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         cout_o,
    output logic         half_o,
    output logic         ovf_o
);
    localparam int unsigned HW = W / 2;

    logic [W:0]  wide;
    logic [HW:0] low;

    always_comb begin
        if (sub_i) begin
            wide = {1'b0, x_i} - {1'b0, y_i} - {{W{1'b0}}, cin_i};
            low  = {1'b0, x_i[HW-1:0]} - {1'b0, y_i[HW-1:0]} - {{HW{1'b0}}, cin_i};
        end else begin
            wide = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
            low  = {1'b0, x_i[HW-1:0]} + {1'b0, y_i[HW-1:0]} + {{HW{1'b0}}, cin_i};
        end
        res_o  = wide[W-1:0];
        cout_o = wide[W];
        half_o = low[HW];
        if (sub_i)
            ovf_o = (x_i[W-1] != y_i[W-1]) && (wide[W-1] != x_i[W-1]);
        else
            ovf_o = (x_i[W-1] == y_i[W-1]) && (wide[W-1] != x_i[W-1]);
    end

    // R4: an addition of operands with different signs can never overflow
    always_comb begin
        if (!sub_i && (x_i[W-1] != y_i[W-1]))
            a_r4_no_mixed_add_overflow: assert (!ovf_o);
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = x_i & y_i;
            OP_OR:   res_o = x_i | y_i;
            OP_XOR:  res_o = x_i ^ y_i;
            OP_CPL:  res_o = ~x_i;
            default: res_o = x_i;
        endcase
    end

    // R8: OR result covers every bit of both operands
    always_comb begin
        if (op_i == OP_OR)
            a_r8_or_covers: assert ((res_o & x_i) == x_i && (res_o & y_i) == y_i);
    end

endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj
    import alu8_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic [W-1:0] acc_i,
    input  logic         h_i,
    input  logic         n_i,
    input  logic         c_i,
    output logic [W-1:0] res_o,
    output logic         h_o,
    output logic         c_o
);
    localparam int unsigned HW      = W / 2;
    localparam logic [HW-1:0] DIGMAX = HW'(9);
    localparam logic [HW-1:0] DIGLOW = HW'(6);
    localparam logic [W-1:0]  TOPMAX = {DIGMAX, DIGMAX};
    localparam logic [W-1:0]  LO_FIX = {{HW{1'b0}}, DIGLOW};
    localparam logic [W-1:0]  HI_FIX = {DIGLOW, {HW{1'b0}}};

    logic         lo_big;
    logic         hi_big;
    logic [W-1:0] fix;

    always_comb begin
        lo_big = acc_i[HW-1:0] > DIGMAX;
        hi_big = acc_i > TOPMAX;
        fix    = '0;
        if (lo_big || h_i)
            fix = fix | LO_FIX;
        if (hi_big || c_i)
            fix = fix | HI_FIX;
        res_o = n_i ? (acc_i - fix) : (acc_i + fix);
        c_o   = c_i || hi_big;
        h_o   = n_i ? (h_i && (acc_i[HW-1:0] < DIGLOW)) : lo_big;
    end

    // R11: carry out never drops a carry that came in
    always_comb begin
        if (c_i)
            a_r11_carry_sticky: assert (c_o);
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [7:0] acc_i,
    input  logic [7:0] opnd_i,
    input  logic [7:0] flags_i,
    input  logic [3:0] op_i,
    output logic [7:0] result_o,
    output logic [7:0] flags_o,
    output logic       acc_we_o
);
    alu_op_e       op;
    flag_t         fin;
    flag_t         fout;

    logic [DW-1:0] as_x;
    logic [DW-1:0] as_y;
    logic          as_cin;
    logic          as_sub;
    logic [DW-1:0] as_res;
    logic          as_cout;
    logic          as_half;
    logic          as_ovf;

    logic [DW-1:0] lg_res;
    logic [DW-1:0] da_res;
    logic          da_h;
    logic          da_c;

    logic [DW-1:0] res;
    logic [DW-1:0] shown;

    assign op  = alu_op_e'(op_i);
    assign fin = flag_t'(flags_i);

    always_comb begin
        as_sub = is_subtract(op);
        as_x   = (op == OP_NEG) ? '0 : acc_i;
        as_y   = (op == OP_NEG) ? acc_i : opnd_i;
        as_cin = ((op == OP_ADC) || (op == OP_SBC)) ? fin.c : 1'b0;
    end

    alu8_addsub #(.W(DW)) u_addsub (
        .x_i    (as_x),
        .y_i    (as_y),
        .cin_i  (as_cin),
        .sub_i  (as_sub),
        .res_o  (as_res),
        .cout_o (as_cout),
        .half_o (as_half),
        .ovf_o  (as_ovf)
    );

    alu8_logic #(.W(DW)) u_logic (
        .op_i  (op),
        .x_i   (acc_i),
        .y_i   (opnd_i),
        .res_o (lg_res)
    );

    alu8_decadj #(.W(DW)) u_decadj (
        .acc_i (acc_i),
        .h_i   (fin.h),
        .n_i   (fin.n),
        .c_i   (fin.c),
        .res_o (da_res),
        .h_o   (da_h),
        .c_o   (da_c)
    );

    always_comb begin
        fout     = fin;
        res      = acc_i;
        acc_we_o = 1'b1;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
                res     = as_res;
                fout.s  = as_res[DW-1];
                fout.z  = (as_res == '0);
                fout.h  = as_half;
                fout.pv = as_ovf;
                fout.n  = as_sub;
                fout.c  = as_cout;
            end
            OP_CMP: begin
                acc_we_o = 1'b0;
                fout.s  = as_res[DW-1];
                fout.z  = (as_res == '0);
                fout.h  = as_half;
                fout.pv = as_ovf;
                fout.n  = 1'b1;
                fout.c  = as_cout;
            end
            OP_AND, OP_OR, OP_XOR: begin
                res     = lg_res;
                fout.s  = lg_res[DW-1];
                fout.z  = (lg_res == '0);
                fout.h  = (op == OP_AND);
                fout.pv = even_par(lg_res);
                fout.n  = 1'b0;
                fout.c  = 1'b0;
            end
            OP_CPL: begin
                res    = lg_res;
                fout.h = 1'b1;
                fout.n = 1'b1;
            end
            OP_CCF: begin
                fout.h = fin.c;
                fout.n = 1'b0;
                fout.c = ~fin.c;
            end
            OP_SCF: begin
                fout.h = 1'b0;
                fout.n = 1'b0;
                fout.c = 1'b1;
            end
            OP_DAA: begin
                res     = da_res;
                fout.s  = da_res[DW-1];
                fout.z  = (da_res == '0);
                fout.h  = da_h;
                fout.pv = even_par(da_res);
                fout.c  = da_c;
            end
            default: begin
                acc_we_o = 1'b0;
            end
        endcase

        shown = (op == OP_CMP) ? as_res : res;
        if (op <= OP_DAA) begin
            fout.b5 = shown[5];
            fout.b3 = shown[3];
        end
        result_o = res;
        flags_o  = fout;
    end

    // R6: compare never changes the accumulator
    always_comb begin
        if (op == OP_CMP)
            a_r6_cmp_no_write: assert (!acc_we_o && result_o == acc_i);
    end

    // R7: AND leaves half-carry set and carry clear
    always_comb begin
        if (op == OP_AND)
            a_r7_and_hc: assert (flags_o[4] && !flags_o[0] && !flags_o[1]);
    end

    // R1: zero flag agrees with the written result
    always_comb begin
        if (acc_we_o && (is_arith(op) || op == OP_AND || op == OP_OR ||
                         op == OP_XOR || op == OP_DAA))
            a_r1_zero_matches: assert (flags_o[6] == (result_o == 8'h00));
    end

    // R12: reserved codes pass flags straight through
    always_comb begin
        if (op > OP_DAA)
            a_r12_reserved_pass: assert (flags_o == flags_i && !acc_we_o);
    end

endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] acc;
    logic [7:0] opnd;
    logic [7:0] fl;
    logic [3:0] op;
    logic [7:0] result;
    logic [7:0] flags;
    logic       we;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    alu8_core dut (
        .acc_i    (acc),
        .opnd_i   (opnd),
        .flags_i  (fl),
        .op_i     (op),
        .result_o (result),
        .flags_o  (flags),
        .acc_we_o (we)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [3:0] o, input logic [7:0] a,
                         input logic [7:0] b, input logic [7:0] f);
        @(negedge clk);
        op = o; acc = a; opnd = b; fl = f;
        #2;
    endtask

    task automatic expect3(input string tag, input logic [7:0] r,
                           input logic [7:0] f, input logic w);
        chk({tag, " result"}, result, r);
        chk({tag, " flags"}, flags, f);
        chk({tag, " we"}, {7'd0, we}, {7'd0, w});
    endtask

    task automatic t_reset;
        apply(4'd0, 8'h00, 8'h00, 8'h00);
        expect3("R1 idle add zero", 8'h00, 8'h40, 1'b1);
    endtask

    task automatic t_add;
        apply(4'd0, 8'h0F, 8'h01, 8'h01);
        expect3("R2 R5 add half", 8'h10, 8'h10, 1'b1);
        apply(4'd1, 8'h7F, 8'h00, 8'h01);
        expect3("R2 R4 adc overflow", 8'h80, 8'h94, 1'b1);
        apply(4'd0, 8'hFF, 8'h01, 8'h00);
        expect3("R2 add wrap", 8'h00, 8'h51, 1'b1);
    endtask

    task automatic t_sub;
        apply(4'd2, 8'h10, 8'h01, 8'h00);
        expect3("R3 R5 sub borrow nibble", 8'h0F, 8'h1A, 1'b1);
        apply(4'd3, 8'h80, 8'h00, 8'h01);
        expect3("R3 R4 sbc overflow", 8'h7F, 8'h3E, 1'b1);
        apply(4'd2, 8'h00, 8'h01, 8'h00);
        expect3("R3 sub borrow", 8'hFF, 8'hBB, 1'b1);
    endtask

    task automatic t_cmp;
        apply(4'd4, 8'h05, 8'h05, 8'h00);
        expect3("R6 cmp equal", 8'h05, 8'h42, 1'b0);
        apply(4'd4, 8'h03, 8'h05, 8'h00);
        expect3("R6 cmp less", 8'h03, 8'hBB, 1'b0);
    endtask

    task automatic t_neg;
        apply(4'd8, 8'h80, 8'h00, 8'h00);
        expect3("R3 R4 neg 80", 8'h80, 8'h87, 1'b1);
        apply(4'd8, 8'h01, 8'h00, 8'h00);
        expect3("R3 neg 01", 8'hFF, 8'hBB, 1'b1);
        apply(4'd8, 8'h00, 8'h00, 8'h01);
        expect3("R3 neg 00", 8'h00, 8'h42, 1'b1);
    endtask

    task automatic t_logic;
        apply(4'd5, 8'hF0, 8'h3C, 8'h01);
        expect3("R7 and", 8'h30, 8'h34, 1'b1);
        apply(4'd5, 8'h0F, 8'hF0, 8'h01);
        expect3("R7 and zero", 8'h00, 8'h54, 1'b1);
        apply(4'd6, 8'h01, 8'h02, 8'h11);
        expect3("R8 or", 8'h03, 8'h04, 1'b1);
        apply(4'd7, 8'hFF, 8'h7F, 8'h00);
        expect3("R8 xor", 8'h80, 8'h80, 1'b1);
        apply(4'd7, 8'h01, 8'h00, 8'h01);
        expect3("R8 xor odd", 8'h01, 8'h00, 1'b1);
    endtask

    task automatic t_cpl_carry;
        apply(4'd9, 8'h5A, 8'h00, 8'hC5);
        expect3("R9 cpl", 8'hA5, 8'hF7, 1'b1);
        apply(4'd11, 8'h00, 8'h00, 8'hD6);
        expect3("R10 scf", 8'h00, 8'hC5, 1'b1);
        apply(4'd10, 8'h00, 8'h00, 8'h01);
        expect3("R10 ccf set", 8'h00, 8'h10, 1'b1);
        apply(4'd10, 8'h00, 8'h00, 8'h00);
        expect3("R10 ccf clear", 8'h00, 8'h01, 1'b1);
    endtask

    task automatic t_daa;
        apply(4'd12, 8'h3C, 8'h00, 8'h00);
        expect3("R11 daa add low", 8'h42, 8'h14, 1'b1);
        apply(4'd12, 8'h9A, 8'h00, 8'h00);
        expect3("R11 daa add both", 8'h00, 8'h55, 1'b1);
        apply(4'd12, 8'h2D, 8'h00, 8'h12);
        expect3("R11 daa sub low", 8'h27, 8'h26, 1'b1);
        apply(4'd12, 8'hF0, 8'h00, 8'h03);
        expect3("R11 daa sub high", 8'h90, 8'h87, 1'b1);
    endtask

    task automatic t_reserved;
        apply(4'd14, 8'h33, 8'h44, 8'hA5);
        expect3("R12 reserved", 8'h33, 8'hA5, 1'b0);
        apply(4'd15, 8'h00, 8'hFF, 8'h5A);
        expect3("R12 reserved top", 8'h00, 8'h5A, 1'b0);
    endtask

    initial begin
        acc = 8'h00; opnd = 8'h00; fl = 8'h00; op = 4'd0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset;
        t_add;
        t_sub;
        t_cmp;
        t_neg;
        t_logic;
        t_cpl_carry;
        t_daa;
        t_reserved;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule